// File: doc/BRIEF.md
# Operand Field Substitution Stage

This stage rewrites register-address fields of instructions in flight. It gives indirect register addressing without writing instruction storage. A prefix instruction names one or two operands. Each operand is either an immediate held in the prefix's own field or the contents of a register that the decoder has already read. The stage keeps the low bits of the chosen value. When the next ordinary instruction arrives, the stage puts those bits into that instruction's destination field, its source field, or both. The operand reads downstream then use the new addresses.

The stage sits between decode and operand fetch and adds one register stage. Prefixes are absorbed and never appear at the output. Ordinary instructions leave one cycle after they enter, rewritten or unchanged. A flush input from branch or cancellation logic drops the instruction offered in that cycle. It also forgets any substitution that is waiting. Instruction memory is never touched, so the same rule holds whether code was fetched from local or shared memory.

Top module: `altsub_unit`

## Requirements
- R1: Under reset, and in the first cycle after it, `out_valid` is low. No substitution survives a reset.
- R2: A prefix of kind 1 (substitute destination) makes the next ordinary instruction (kind 0) leave with its destination field, bits [17:9], replaced by the prefix's destination-slot value. All other bits are unchanged.
- R3: A prefix of kind 2 (substitute source) makes the next ordinary instruction leave with its source field, bits [8:0], replaced by the prefix's source-slot value. All other bits are unchanged.
- R4: A prefix of kind 3 replaces both fields at once: the destination-slot value goes to bits [17:9] and the source-slot value to bits [8:0]. Slot values $20 and $30 ahead of an instruction with zero fields give destination $20 and source $30.
- R5: A slot value is the prefix's own field (destination bits [17:9], source bits [8:0]) when that slot's immediate flag is set (bit 19 for destination, bit 18 for source). Otherwise it is the low 9 bits of the register contents on `in_dreg` or `in_sreg`.
- R6: A substitution applies to exactly one ordinary instruction. The one after it leaves unchanged.
- R7: `flush` drops the instruction offered in the same cycle, so no output follows, and clears any pending substitution.
- R8: A prefix that arrives while another is pending replaces it completely. Fields named only by the earlier prefix are not substituted.
- R9: An ordinary instruction accepted without flush appears on `out_word` with `out_valid` high exactly one cycle later, unchanged if nothing is pending. A prefix never produces output.
- R10: A pending substitution waits through cycles with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present this cycle |
| in_kind | input | 2 | 0 ordinary, 1 substitute destination, 2 substitute source, 3 substitute both |
| in_word | input | INSN_W | Instruction word with fields and immediate flags |
| in_dreg | input | DATA_W | Register contents addressed by the destination field |
| in_sreg | input | DATA_W | Register contents addressed by the source field |
| flush | input | 1 | Discard this cycle's instruction and any pending substitution |
| out_valid | output | 1 | Rewritten ordinary instruction present |
| out_word | output | INSN_W | Instruction word after substitution |

## Verification
The bench builds the stage with its default parameters: a 32-bit word, 32-bit register data and 9-bit fields at the low end of the word. With these values, register contents wider than a field reach the truncation in R5, and bits 31..18 above both fields can be checked for preservation. The scoreboard predicts every cycle, both idle and busy, from a model of the pending state. This exposes an output that should not appear after a prefix or a flush, as well as a substitution that is missing or left over.

// File: rtl/altsub_pkg.sv
`timescale 1ns/1ps
package altsub_pkg;
    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_SUB_D  = 2'd1,
        KIND_SUB_S  = 2'd2,
        KIND_SUB_DS = 2'd3
    } alt_kind_e;

    localparam int SLOT_D = 0;
    localparam int SLOT_S = 1;
    localparam int SLOTS  = 2;
endpackage

// File: rtl/altsub_pick.sv
`timescale 1ns/1ps
module altsub_pick #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 9
) (
    input  logic               use_imm,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [DATA_W-1:0]  reg_val,
    output logic [FIELD_W-1:0] field
);
    // Only the low bits of a register value can name a register.
    logic [FIELD_W-1:0] reg_low;

    assign reg_low = reg_val[FIELD_W-1:0];

    always_comb begin
        if (use_imm) begin
            field = imm_field;
        end else begin
            field = reg_low;
        end
    end
endmodule

// File: rtl/altsub_merge.sv
`timescale 1ns/1ps
module altsub_merge #(
    parameter int INSN_W  = 32,
    parameter int FIELD_W = 9,
    parameter int D_LSB   = 9,
    parameter int S_LSB   = 0
) (
    input  logic [INSN_W-1:0]  word_in,
    input  logic               sub_d,
    input  logic               sub_s,
    input  logic [FIELD_W-1:0] field_d,
    input  logic [FIELD_W-1:0] field_s,
    output logic [INSN_W-1:0]  word_out
);
    always_comb begin
        word_out = word_in;
        if (sub_d) begin
            word_out[D_LSB +: FIELD_W] = field_d;
        end
        if (sub_s) begin
            word_out[S_LSB +: FIELD_W] = field_s;
        end
    end
endmodule

// File: rtl/altsub_unit.sv
`timescale 1ns/1ps
module altsub_unit #(
    parameter int INSN_W   = 32,
    parameter int DATA_W   = 32,
    parameter int FIELD_W  = 9,
    parameter int D_LSB    = 9,
    parameter int S_LSB    = 0,
    parameter int DIMM_BIT = 19,
    parameter int SIMM_BIT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [INSN_W-1:0] in_word,
    input  logic [DATA_W-1:0] in_dreg,
    input  logic [DATA_W-1:0] in_sreg,
    input  logic              flush,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_word
);
    import altsub_pkg::*;

    localparam int SLOT_N = SLOTS;

    typedef struct packed {
        logic               pend_d;
        logic               pend_s;
        logic [FIELD_W-1:0] fld_d;
        logic [FIELD_W-1:0] fld_s;
        logic               ov;
        logic [INSN_W-1:0]  ow;
    } state_t;

    state_t state_d, state_q;

    alt_kind_e kind;
    assign kind = alt_kind_e'(in_kind);

    // Operand slot selection, one picker per slot.
    logic [SLOT_N-1:0]  slot_imm;
    logic [FIELD_W-1:0] slot_own   [SLOT_N];
    logic [DATA_W-1:0]  slot_reg   [SLOT_N];
    logic [FIELD_W-1:0] slot_value [SLOT_N];

    assign slot_imm[SLOT_D] = in_word[DIMM_BIT];
    assign slot_imm[SLOT_S] = in_word[SIMM_BIT];
    assign slot_own[SLOT_D] = in_word[D_LSB +: FIELD_W];
    assign slot_own[SLOT_S] = in_word[S_LSB +: FIELD_W];
    assign slot_reg[SLOT_D] = in_dreg;
    assign slot_reg[SLOT_S] = in_sreg;

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        altsub_pick #(
            .DATA_W (DATA_W),
            .FIELD_W(FIELD_W)
        ) u_pick (
            .use_imm  (slot_imm[g]),
            .imm_field(slot_own[g]),
            .reg_val  (slot_reg[g]),
            .field    (slot_value[g])
        );
    end

    // Rewrite of an ordinary instruction using what is pending.
    logic [INSN_W-1:0] merged_word;

    altsub_merge #(
        .INSN_W (INSN_W),
        .FIELD_W(FIELD_W),
        .D_LSB  (D_LSB),
        .S_LSB  (S_LSB)
    ) u_merge (
        .word_in (in_word),
        .sub_d   (state_q.pend_d),
        .sub_s   (state_q.pend_s),
        .field_d (state_q.fld_d),
        .field_s (state_q.fld_s),
        .word_out(merged_word)
    );

    always_comb begin
        state_d    = state_q;
        state_d.ov = 1'b0;
        if (flush) begin
            state_d.pend_d = 1'b0;
            state_d.pend_s = 1'b0;
        end else if (in_valid) begin
            unique case (kind)
                KIND_PLAIN: begin
                    state_d.ov     = 1'b1;
                    state_d.ow     = merged_word;
                    state_d.pend_d = 1'b0;
                    state_d.pend_s = 1'b0;
                end
                KIND_SUB_D: begin
                    state_d.pend_d = 1'b1;
                    state_d.pend_s = 1'b0;
                    state_d.fld_d  = slot_value[SLOT_D];
                end
                KIND_SUB_S: begin
                    state_d.pend_d = 1'b0;
                    state_d.pend_s = 1'b1;
                    state_d.fld_s  = slot_value[SLOT_S];
                end
                KIND_SUB_DS: begin
                    state_d.pend_d = 1'b1;
                    state_d.pend_s = 1'b1;
                    state_d.fld_d  = slot_value[SLOT_D];
                    state_d.fld_s  = slot_value[SLOT_S];
                end
                default: begin
                    state_d.ov = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.ov;
    assign out_word  = state_q.ow;
endmodule

// File: rtl/altsub_check.sv
`timescale 1ns/1ps
module altsub_check #(
    parameter int INSN_W   = 32,
    parameter int KEEP_LSB = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [INSN_W-1:0] in_word,
    input logic              flush,
    input logic              out_valid,
    input logic [INSN_W-1:0] out_word
);
    logic take_plain;
    assign take_plain = in_valid && (in_kind == 2'd0) && !flush;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_PLAIN_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        take_plain |=> out_valid); // R9

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd0) |=> !out_valid); // R9

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R7

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        take_plain |=> out_word[INSN_W-1:KEEP_LSB] == $past(in_word[INSN_W-1:KEEP_LSB])); // R2

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_plain && $past(take_plain)) |=> out_word == $past(in_word)); // R6
endmodule

bind altsub_unit altsub_check #(
    .INSN_W  (INSN_W),
    .KEEP_LSB(((D_LSB > S_LSB) ? D_LSB : S_LSB) + FIELD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_kind  (in_kind),
    .in_word  (in_word),
    .flush    (flush),
    .out_valid(out_valid),
    .out_word (out_word)
);

// File: tb/altsub_unit_test.sv
`timescale 1ns/1ps
module altsub_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'd0;
    logic [31:0] in_word = '0;
    logic [31:0] in_dreg = '0;
    logic [31:0] in_sreg = '0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    altsub_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_word(in_word), .in_dreg(in_dreg), .in_sreg(in_sreg),
        .flush(flush), .out_valid(out_valid), .out_word(out_word)
    );

    typedef struct {
        bit          v;
        logic [31:0] w;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Bench model of pending state.
    bit         m_pd = 0;
    bit         m_ps = 0;
    logic [8:0] m_fd = '0;
    logic [8:0] m_fs = '0;

    function automatic logic [31:0] mk(input logic [11:0] op, input bit dimm,
                                       input bit simm, input logic [8:0] d,
                                       input logic [8:0] s);
        return {op, dimm, simm, d, s};
    endfunction

    task automatic step(input bit v, input logic [1:0] k, input logic [31:0] w,
                        input logic [31:0] dr, input logic [31:0] sr,
                        input bit fl, input string tag);
        exp_t e;
        logic [8:0] dv;
        logic [8:0] sv;
        @(negedge clk);
        in_valid = v; in_kind = k; in_word = w;
        in_dreg = dr; in_sreg = sr; flush = fl;
        dv = w[19] ? w[17:9] : dr[8:0];
        sv = w[18] ? w[8:0] : sr[8:0];
        e.v = v && !fl && (k == 2'd0);
        e.w = w;
        if (m_pd) e.w[17:9] = m_fd;
        if (m_ps) e.w[8:0] = m_fs;
        e.tag = tag;
        if (fl) begin
            m_pd = 0; m_ps = 0;
        end else if (v) begin
            case (k)
                2'd0: begin m_pd = 0; m_ps = 0; end
                2'd1: begin m_pd = 1; m_ps = 0; m_fd = dv; end
                2'd2: begin m_pd = 0; m_ps = 1; m_fs = sv; end
                default: begin m_pd = 1; m_ps = 1; m_fd = dv; m_fs = sv; end
            endcase
        end
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 0; flush = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 out_valid during reset actual=%b expected=0", out_valid);
        end
        rst_n = 1;
        m_pd = 0; m_ps = 0;
    endtask

    // Monitor: pops one prediction per cycle, a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_valid !== e.v) begin
                    failures++;
                    $display("FAIL %s out_valid actual=%b expected=%b", e.tag, out_valid, e.v);
                end else if (e.v) begin
                    checks++;
                    if (out_word !== e.w) begin
                        failures++;
                        $display("FAIL %s out_word actual=%h expected=%h", e.tag, out_word, e.w);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 50000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
        end
        rst_n = 1;
        idle("R1");

        // R9: plain passes through unchanged
        step(1, 2'd0, mk(12'hABC, 1, 1, 9'h155, 9'h0AA), 32'hFFFF_FFFF, 32'h1, 0, "R9");
        step(1, 2'd0, mk(12'h123, 0, 0, 9'h001, 9'h1FF), 32'h0, 32'h0, 0, "R9");

        // R2 + R5: destination from register, truncated to 9 bits
        step(1, 2'd1, mk(12'h800, 0, 0, 9'h010, 9'h011), 32'h1234_5ABC, 32'h0, 0, "R2");
        step(1, 2'd0, mk(12'h5A5, 0, 0, 9'h000, 9'h077), 32'h0, 32'h0, 0, "R2 R5");

        // R3 + R5: source from immediate
        step(1, 2'd2, mk(12'h801, 0, 1, 9'h0F0, 9'h1C3), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
        step(1, 2'd0, mk(12'hFFF, 1, 1, 9'h1FF, 9'h1FF), 32'h0, 32'h0, 0, "R3 R5");

        // R4: pointers hold $20 and $30, instruction with zero fields
        step(1, 2'd3, mk(12'h802, 0, 0, 9'h040, 9'h041), 32'h0000_0020, 32'h0000_0030, 0, "R4");
        step(1, 2'd0, mk(12'h0A0, 0, 0, 9'h000, 9'h000), 32'h0, 32'h0, 0, "R4");
        // R6: the next one is untouched
        step(1, 2'd0, mk(12'h0A0, 0, 0, 9'h000, 9'h000), 32'h0, 32'h0, 0, "R6");

        // R4 + R5: both slots immediate
        step(1, 2'd3, mk(12'h803, 1, 1, 9'h1AB, 9'h0CD), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 R5");
        step(1, 2'd0, mk(12'h3C3, 1, 0, 9'h111, 9'h022), 32'h0, 32'h0, 0, "R4");

        // R10: pending survives idle cycles
        step(1, 2'd1, mk(12'h804, 1, 0, 9'h07E, 9'h000), 32'h0, 32'h0, 0, "R10");
        idle("R10");
        idle("R10");
        idle("R10");
        step(1, 2'd0, mk(12'h777, 0, 0, 9'h100, 9'h101), 32'h0, 32'h0, 0, "R10");

        // R8: second prefix replaces, destination no longer substituted
        step(1, 2'd1, mk(12'h805, 1, 0, 9'h0EE, 9'h000), 32'h0, 32'h0, 0, "R8");
        step(1, 2'd2, mk(12'h806, 0, 0, 9'h000, 9'h000), 32'h0, 32'h0000_0099, 0, "R8");
        step(1, 2'd0, mk(12'h246, 0, 0, 9'h033, 9'h044), 32'h0, 32'h0, 0, "R8");

        // R7: flush alone clears pending
        step(1, 2'd3, mk(12'h807, 1, 1, 9'h0AA, 9'h0BB), 32'h0, 32'h0, 0, "R7");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, "R7");
        step(1, 2'd0, mk(12'h135, 0, 0, 9'h012, 9'h034), 32'h0, 32'h0, 0, "R7");
        // R7: flush drops the instruction offered with it and the pending prefix
        step(1, 2'd1, mk(12'h808, 1, 0, 9'h0C0, 9'h000), 32'h0, 32'h0, 0, "R7");
        step(1, 2'd0, mk(12'h999, 0, 0, 9'h055, 9'h066), 32'h0, 32'h0, 1, "R7");
        step(1, 2'd0, mk(12'h99A, 0, 0, 9'h055, 9'h066), 32'h0, 32'h0, 0, "R7");
        // R7: flush on a prefix cycle means the prefix never takes effect
        step(1, 2'd2, mk(12'h809, 0, 1, 9'h000, 9'h1EE), 32'h0, 32'h0, 1, "R7");
        step(1, 2'd0, mk(12'h99B, 0, 0, 9'h0F1, 9'h0F2), 32'h0, 32'h0, 0, "R7");

        // R1: reset clears a pending substitution
        step(1, 2'd3, mk(12'h80A, 1, 1, 9'h1F0, 9'h00F), 32'h0, 32'h0, 0, "R1");
        do_reset();
        step(1, 2'd0, mk(12'h4D4, 0, 0, 9'h020, 9'h030), 32'h0, 32'h0, 0, "R1");

        idle("end");
        idle("end");
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R9 scoreboard left actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule